// File: doc/BRIEF.md
# Signal-presence, mute and sleep controller

This block is the digital control core of a coaxial cable receiver front end. It takes a raw energy flag from the analog detector, an 8-bit measured cable-length code, a rate flag, and either pin-level or register-level copies of the mute, bypass and sleep controls. From these it derives a "no carrier" indication, a forced-high level for the output data path, equalizer enable and bypass controls, a power-down request and a "ready" indication that marks full operation.

The no-carrier flag combines a missing-energy condition with an optional cable-length limit. That limit comes either from an external comparator flag or from a 5-bit digital code in 10 m steps. The power logic keeps the equalizer on, sleeps it after the input has been quiet for a fixed time, or forces it to sleep. When the input returns it wakes the equalizer automatically and raises ready only after a settling delay. Both delays are set in microseconds against a parameterised reference clock.

Top module: `sigdet_ctl`

## Requirements
- R1: `no_carrier` is 1 whenever `energy_det` is 0 or the selected length limit is hit, and is 0 otherwise. It is updated one clock after the inputs are sampled.
- R2: With `reg_ctl`=1, `reg_thr_dig`=1 and `rate_sd`=0, the limit is hit when `cable_len` >= 8*(`reg_thr`+1). Code 0 hits at 8, code 15 at 128, code 30 at 248, and code 31 never hits.
- R3: With `rate_sd`=1, the digital limit moves up by 16 length codes. Code 0 hits at 24, and code 29 cannot be reached by an 8-bit length.
- R4: When `reg_ctl`=0 or `reg_thr_dig`=0, the limit is taken from `pin_thr_flag` and the digital code is ignored.
- R5: With `reg_ctl`=0, the block follows `pin_mute`, `pin_bypass` and `pin_autosleep`, where `pin_autosleep`=1 acts as sleep mode 01 and 0 acts as mode 00. With `reg_ctl`=1, it follows `reg_mute`, `reg_bypass` and `reg_sleep`.
- R6: While awake with mute active, `out_mute`=1 (the data output is held at logic 1), `eq_bypass`=0 and `eq_en`=1. Mute wins over bypass.
- R7: While awake with bypass active and mute inactive, `eq_bypass`=1 and `eq_en`=0.
- R8: Sleep mode 10 asserts `pwr_down` one clock later, whatever `energy_det` does. While `pwr_down`=1, `out_mute`, `eq_bypass`, `eq_en` and `ready` are all 0.
- R9: In sleep mode 01, `pwr_down` rises on the (PDN_CYC+1)-th consecutive clock edge that samples `energy_det`=0. A sample of 1 before that edge cancels the countdown and leaves `ready` at 1.
- R10: `pwr_down` falls one clock after the sleep cause ends. `ready` then stays 0 for WAKE_CYC-1 more clocks and rises on the WAKE_CYC-th clock after the fall.
- R11: Sleep modes 00 and 11 never sleep. Selecting either while asleep wakes the block.
- R12: Reset (`rst_n`=0) and `acq_rst`=1 return the block to the awake, acquiring state: `pwr_down`=0, `ready`=0, timers cleared. During reset, `no_carrier`=1, `out_mute`=0, `eq_bypass`=0 and `eq_en`=1. `ready` rises WAKE_CYC clocks after release, and the control inputs keep their effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_rst | input | 1 | Synchronous acquisition restart |
| energy_det | input | 1 | 1 = input energy present |
| cable_len | input | LEN_W | Measured cable length, 1.25 m per code |
| rate_sd | input | 1 | 1 = standard-definition rate |
| reg_ctl | input | 1 | 1 = register-level controls, 0 = pin-level |
| pin_mute | input | 1 | Pin mute request |
| pin_bypass | input | 1 | Pin bypass request |
| pin_autosleep | input | 1 | Pin auto-sleep enable |
| pin_thr_flag | input | 1 | External length-limit comparator flag |
| reg_mute | input | 1 | Register mute request |
| reg_bypass | input | 1 | Register bypass request |
| reg_sleep | input | 2 | Sleep mode: 00 on, 01 auto, 10 forced, 11 reserved (on) |
| reg_thr_dig | input | 1 | 1 = use the digital length limit |
| reg_thr | input | THR_W | Digital limit, 10 m per step, all ones = off |
| no_carrier | output | 1 | 1 = no valid input |
| out_mute | output | 1 | 1 = data output forced high |
| eq_bypass | output | 1 | 1 = equalizer bypassed |
| eq_en | output | 1 | 1 = equalizer filter active |
| pwr_down | output | 1 | Power-down request |
| ready | output | 1 | Full operation reached |

## Verification
The carrier, mute, bypass and enable outputs, and `pwr_down` on a forced or cancelled sleep, change on the first clock edge after the inputs are sampled. Auto-sleep power-down lands on the (PDN_CYC+1)-th quiet edge, and `ready` lands WAKE_CYC edges after `pwr_down` falls or a restart is released. The bench drives inputs on falling edges and samples on a later falling edge, after exactly the number of rising edges each result needs. For the timers it checks both the last edge before the change and the edge that makes it.

// File: rtl/sigdet_pkg.sv
package sigdet_pkg;

   typedef enum logic [1:0] {
      SLP_OFF   = 2'b00,
      SLP_AUTO  = 2'b01,
      SLP_FORCE = 2'b10,
      SLP_RSVD  = 2'b11
   } slp_mode_t;

   typedef enum logic [1:0] {
      PS_ON    = 2'b00,
      PS_DRAIN = 2'b01,
      PS_SLEEP = 2'b10,
      PS_WAKE  = 2'b11
   } pwr_st_t;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sigdet_ctlsel.sv
module sigdet_ctlsel
   import sigdet_pkg::*;
(
   input  logic       reg_ctl,
   input  logic       pin_mute,
   input  logic       pin_bypass,
   input  logic       pin_autosleep,
   input  logic       reg_mute,
   input  logic       reg_bypass,
   input  logic [1:0] reg_sleep,
   input  logic       reg_thr_dig,
   output logic       mute_e,
   output logic       byp_e,
   output slp_mode_t  smode,
   output logic       use_dig
);

   always_comb begin
      if (reg_ctl) begin
         mute_e  = reg_mute;
         byp_e   = reg_bypass;
         smode   = slp_mode_t'(reg_sleep);
         use_dig = reg_thr_dig;
      end else begin
         mute_e  = pin_mute;
         byp_e   = pin_bypass;
         smode   = pin_autosleep ? SLP_AUTO : SLP_OFF;
         use_dig = 1'b0;
      end
   end

endmodule

// File: rtl/sigdet_thresh.sv
module sigdet_thresh #(
   parameter int LEN_W      = 8,
   parameter int THR_W      = 5,
   parameter int STEP_CODES = 8,
   parameter int SD_OFFSET  = 16
) (
   input  logic [LEN_W-1:0] cable_len,
   input  logic             rate_sd,
   input  logic             use_dig,
   input  logic [THR_W-1:0] thr_code,
   input  logic             pin_flag,
   output logic             hit
);

   localparam int LIM_MAX = (1 << THR_W) * STEP_CODES + SD_OFFSET;
   localparam int LIM_W   = $clog2(LIM_MAX + 1);
   localparam int CMP_W   = (LIM_W > LEN_W) ? LIM_W : LEN_W;

   generate
      if (THR_W < 2 || STEP_CODES < 1 || SD_OFFSET < 0) begin : g_bad_cfg
         $error("sigdet_thresh: illegal threshold parameters");
      end
   endgenerate

   logic [CMP_W-1:0] offs;
   logic [CMP_W-1:0] lim;
   logic [CMP_W-1:0] len_x;
   logic             dig_hit;

   generate
      if (SD_OFFSET > 0) begin : g_sd_offs
         assign offs = rate_sd ? CMP_W'(SD_OFFSET) : '0;
      end else begin : g_no_offs
         assign offs = '0;
      end
   endgenerate

   always_comb begin
      len_x   = CMP_W'(cable_len);
      lim     = (CMP_W'(thr_code) + CMP_W'(1)) * CMP_W'(STEP_CODES) + offs;
      dig_hit = (thr_code != {THR_W{1'b1}}) && (len_x >= lim);
      hit     = use_dig ? dig_hit : pin_flag;
   end

   always_comb begin
      if (use_dig && (thr_code == {THR_W{1'b1}})) begin
         // R2
         never_mute_chk: assert (!hit);
      end
   end

endmodule

// File: rtl/sigdet_pwr_fsm.sv
module sigdet_pwr_fsm
   import sigdet_pkg::*;
#(
   parameter int PDN_CYC  = 1900,
   parameter int WAKE_CYC = 50000
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      acq_rst,
   input  logic      energy_det,
   input  slp_mode_t smode,
   output logic      pwr_down,
   output logic      ready,
   output logic      sleep_nxt
);

   localparam int CNT_MAX = imax(PDN_CYC, WAKE_CYC);
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   generate
      if (PDN_CYC < 1 || WAKE_CYC < 1) begin : g_bad_cyc
         $error("sigdet_pwr_fsm: timer lengths must be at least one cycle");
      end
   endgenerate

   pwr_st_t          st, nxt;
   logic [CNT_W-1:0] cnt, cnt_nxt;
   logic             force_s, lost_s;

   assign force_s = (smode == SLP_FORCE);
   assign lost_s  = (smode == SLP_AUTO) && !energy_det;

   always_comb begin
      nxt     = st;
      cnt_nxt = cnt;
      if (acq_rst) begin
         nxt     = PS_WAKE;
         cnt_nxt = '0;
      end else begin
         case (st)
            PS_ON: begin
               if (force_s) nxt = PS_SLEEP;
               else if (lost_s) begin
                  nxt     = PS_DRAIN;
                  cnt_nxt = '0;
               end
            end
            PS_DRAIN: begin
               if (force_s) nxt = PS_SLEEP;
               else if (!lost_s) nxt = PS_ON;
               else if (cnt == CNT_W'(PDN_CYC - 1)) nxt = PS_SLEEP;
               else cnt_nxt = cnt + CNT_W'(1);
            end
            PS_SLEEP: begin
               if (!(force_s || lost_s)) begin
                  nxt     = PS_WAKE;
                  cnt_nxt = '0;
               end
            end
            default: begin
               if (force_s || lost_s) nxt = PS_SLEEP;
               else if (cnt == CNT_W'(WAKE_CYC - 1)) nxt = PS_ON;
               else cnt_nxt = cnt + CNT_W'(1);
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= PS_WAKE;
         cnt <= '0;
      end else begin
         st  <= nxt;
         cnt <= cnt_nxt;
      end
   end

   assign pwr_down  = (st == PS_SLEEP);
   assign ready     = (st == PS_ON) || (st == PS_DRAIN);
   assign sleep_nxt = (nxt == PS_SLEEP);

   // R8
   force_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smode == SLP_FORCE && !acq_rst) |=> pwr_down);

   // R12
   acq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acq_rst |=> (!pwr_down && !ready));

   // R10
   wake_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_down) |-> !ready);

   // R9
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CNT_W'(CNT_MAX));

endmodule

// File: rtl/sigdet_ctl.sv
module sigdet_ctl
   import sigdet_pkg::*;
#(
   parameter int LEN_W       = 8,
   parameter int THR_W       = 5,
   parameter int STEP_CODES  = 8,
   parameter int SD_OFFSET   = 16,
   parameter int REF_CLK_KHZ = 10000,
   parameter int PDN_US      = 190,
   parameter int WAKE_US     = 5000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acq_rst,
   input  logic             energy_det,
   input  logic [LEN_W-1:0] cable_len,
   input  logic             rate_sd,
   input  logic             reg_ctl,
   input  logic             pin_mute,
   input  logic             pin_bypass,
   input  logic             pin_autosleep,
   input  logic             pin_thr_flag,
   input  logic             reg_mute,
   input  logic             reg_bypass,
   input  logic [1:0]       reg_sleep,
   input  logic             reg_thr_dig,
   input  logic [THR_W-1:0] reg_thr,
   output logic             no_carrier,
   output logic             out_mute,
   output logic             eq_bypass,
   output logic             eq_en,
   output logic             pwr_down,
   output logic             ready
);

   localparam int PDN_CYC  = REF_CLK_KHZ * PDN_US / 1000;
   localparam int WAKE_CYC = REF_CLK_KHZ * WAKE_US / 1000;

   generate
      if (PDN_US >= 200) begin : g_bad_pdn
         $error("sigdet_ctl: power-down delay must stay below 200 us");
      end
      if (PDN_CYC < 1 || WAKE_CYC < 1) begin : g_bad_clk
         $error("sigdet_ctl: reference clock too slow for the delays");
      end
   endgenerate

   logic      mute_e, byp_e, use_dig, thr_hit, sleep_nxt;
   slp_mode_t smode;

   sigdet_ctlsel u_sel (
      .reg_ctl       (reg_ctl),
      .pin_mute      (pin_mute),
      .pin_bypass    (pin_bypass),
      .pin_autosleep (pin_autosleep),
      .reg_mute      (reg_mute),
      .reg_bypass    (reg_bypass),
      .reg_sleep     (reg_sleep),
      .reg_thr_dig   (reg_thr_dig),
      .mute_e        (mute_e),
      .byp_e         (byp_e),
      .smode         (smode),
      .use_dig       (use_dig)
   );

   sigdet_thresh #(
      .LEN_W      (LEN_W),
      .THR_W      (THR_W),
      .STEP_CODES (STEP_CODES),
      .SD_OFFSET  (SD_OFFSET)
   ) u_thr (
      .cable_len (cable_len),
      .rate_sd   (rate_sd),
      .use_dig   (use_dig),
      .thr_code  (reg_thr),
      .pin_flag  (pin_thr_flag),
      .hit       (thr_hit)
   );

   sigdet_pwr_fsm #(
      .PDN_CYC  (PDN_CYC),
      .WAKE_CYC (WAKE_CYC)
   ) u_pwr (
      .clk        (clk),
      .rst_n      (rst_n),
      .acq_rst    (acq_rst),
      .energy_det (energy_det),
      .smode      (smode),
      .pwr_down   (pwr_down),
      .ready      (ready),
      .sleep_nxt  (sleep_nxt)
   );

   logic byp_win;
   assign byp_win = !mute_e && byp_e;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         no_carrier <= 1'b1;
         out_mute   <= 1'b0;
         eq_bypass  <= 1'b0;
         eq_en      <= 1'b1;
      end else begin
         no_carrier <= !energy_det || thr_hit;
         out_mute   <= !sleep_nxt && mute_e;
         eq_bypass  <= !sleep_nxt && byp_win;
         eq_en      <= !sleep_nxt && !byp_win;
      end
   end

   // R8
   sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |-> (!out_mute && !eq_bypass && !eq_en));

   // R6
   mute_over_byp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_mute |-> (!eq_bypass && eq_en));

   // R1
   nocar_energy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !energy_det |=> no_carrier);

endmodule

// File: tb/sim_sigdet_ctl.sv
module sim_sigdet_ctl;

   localparam int CLK_PERIOD = 10;
   localparam int KHZ  = 100;
   localparam int PDN  = 8;    // 100 kHz * 80 us
   localparam int WAKE = 12;   // 100 kHz * 120 us

   logic       clk = 1'b0;
   logic       rst_n, acq_rst, energy_det, rate_sd, reg_ctl;
   logic       pin_mute, pin_bypass, pin_autosleep, pin_thr_flag;
   logic       reg_mute, reg_bypass, reg_thr_dig;
   logic [1:0] reg_sleep;
   logic [4:0] reg_thr;
   logic [7:0] cable_len;
   logic       no_carrier, out_mute, eq_bypass, eq_en, pwr_down, ready;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sigdet_ctl #(
      .REF_CLK_KHZ (KHZ),
      .PDN_US      (80),
      .WAKE_US     (120)
   ) u0 (
      .clk (clk), .rst_n (rst_n), .acq_rst (acq_rst), .energy_det (energy_det),
      .cable_len (cable_len), .rate_sd (rate_sd), .reg_ctl (reg_ctl),
      .pin_mute (pin_mute), .pin_bypass (pin_bypass), .pin_autosleep (pin_autosleep),
      .pin_thr_flag (pin_thr_flag), .reg_mute (reg_mute), .reg_bypass (reg_bypass),
      .reg_sleep (reg_sleep), .reg_thr_dig (reg_thr_dig), .reg_thr (reg_thr),
      .no_carrier (no_carrier), .out_mute (out_mute), .eq_bypass (eq_bypass),
      .eq_en (eq_en), .pwr_down (pwr_down), .ready (ready)
   );

   // flags: reg_ctl energy pin_mute pin_bypass pin_thr reg_mute reg_bypass thr_dig rate_sd
   // expect: no_carrier out_mute eq_bypass eq_en
   typedef struct packed {
      logic [8:0] flags;
      logic [4:0] thr;
      logic [7:0] len;
      logic [3:0] expv;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VEC [0:NV-1] = '{
      {9'b0_1_000_00_0_0, 5'd0,  8'd0,   4'b0001, 4'd1},  // R1 signal present
      {9'b0_0_000_00_0_0, 5'd0,  8'd0,   4'b1001, 4'd1},  // R1 no energy
      {9'b0_1_001_00_0_0, 5'd0,  8'd0,   4'b1001, 4'd4},  // R4 pin flag
      {9'b0_1_100_00_0_0, 5'd0,  8'd0,   4'b0101, 4'd6},  // R6 pin mute
      {9'b0_1_010_00_0_0, 5'd0,  8'd0,   4'b0010, 4'd7},  // R7 pin bypass
      {9'b0_1_110_00_0_0, 5'd0,  8'd0,   4'b0101, 4'd6},  // R6 mute over bypass
      {9'b1_1_110_00_0_0, 5'd0,  8'd0,   4'b0001, 4'd5},  // R5 pins ignored
      {9'b1_1_000_10_0_0, 5'd0,  8'd0,   4'b0101, 4'd6},  // R6 register mute
      {9'b1_1_000_01_0_0, 5'd0,  8'd0,   4'b0010, 4'd7},  // R7 register bypass
      {9'b1_1_000_00_1_0, 5'd0,  8'd7,   4'b0001, 4'd2},  // R2 below code 0
      {9'b1_1_000_00_1_0, 5'd0,  8'd8,   4'b1001, 4'd2},  // R2 at code 0
      {9'b1_1_000_00_1_0, 5'd15, 8'd127, 4'b0001, 4'd2},  // R2 below code 15
      {9'b1_1_000_00_1_0, 5'd15, 8'd128, 4'b1001, 4'd2},  // R2 at code 15
      {9'b1_1_000_00_1_0, 5'd31, 8'd255, 4'b0001, 4'd2},  // R2 code 31 off
      {9'b1_1_000_00_1_0, 5'd30, 8'd248, 4'b1001, 4'd2},  // R2 at code 30
      {9'b1_1_000_00_1_0, 5'd30, 8'd247, 4'b0001, 4'd2},  // R2 below code 30
      {9'b1_1_000_00_1_1, 5'd0,  8'd23,  4'b0001, 4'd3},  // R3 below
      {9'b1_1_000_00_1_1, 5'd0,  8'd24,  4'b1001, 4'd3},  // R3 at
      {9'b1_1_000_00_1_1, 5'd29, 8'd255, 4'b0001, 4'd3},  // R3 out of range
      {9'b1_1_001_00_0_0, 5'd0,  8'd255, 4'b1001, 4'd4},  // R4 register mode, pin flag
      {9'b1_1_000_00_0_0, 5'd0,  8'd255, 4'b0001, 4'd4},  // R4 digital unused
      {9'b0_1_000_00_1_0, 5'd0,  8'd255, 4'b0001, 4'd4}   // R4 pin mode ignores code
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   task automatic report;
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
   end

   initial begin
      rst_n = 0; acq_rst = 0; energy_det = 0; rate_sd = 0; reg_ctl = 0;
      pin_mute = 0; pin_bypass = 0; pin_autosleep = 0; pin_thr_flag = 0;
      reg_mute = 0; reg_bypass = 0; reg_thr_dig = 0; reg_sleep = 2'b00;
      reg_thr = '0; cable_len = '0;
      tick(2);
      // R12 reset values
      chk("R12 reset outputs", {no_carrier, out_mute, eq_bypass, eq_en}, 4'b1001);
      chk("R12 reset power", {2'b00, pwr_down, ready}, 4'b0000);
      energy_det = 1;
      rst_n = 1;
      tick(WAKE - 1);
      chk("R12 ready held after reset", {3'b000, ready}, 4'b0000);
      tick(1);
      chk("R12 ready after reset", {3'b000, ready}, 4'b0001);

      for (int i = 0; i < NV; i++) begin
         {reg_ctl, energy_det, pin_mute, pin_bypass, pin_thr_flag,
          reg_mute, reg_bypass, reg_thr_dig, rate_sd} = VEC[i].flags;
         reg_thr   = VEC[i].thr;
         cable_len = VEC[i].len;
         tick(1);
         chk($sformatf("R%0d vector %0d", VEC[i].req, i),
             {no_carrier, out_mute, eq_bypass, eq_en}, VEC[i].expv);
      end

      reg_ctl = 1; energy_det = 1; pin_mute = 0; pin_bypass = 0; pin_thr_flag = 0;
      reg_mute = 1; reg_bypass = 0; reg_thr_dig = 0; rate_sd = 0; cable_len = '0;
      tick(1);
      // R8 forced sleep
      reg_sleep = 2'b10;
      tick(1);
      chk("R8 forced sleep", {pwr_down, out_mute, eq_bypass, eq_en}, 4'b1000);
      chk("R8 ready low asleep", {3'b000, ready}, 4'b0000);
      energy_det = 0; tick(2); energy_det = 1; tick(2);
      chk("R8 sleep ignores energy", {3'b000, pwr_down}, 4'b0001);
      // R11 reserved mode wakes; R6 mute back in force
      reg_sleep = 2'b11;
      tick(1);
      chk("R11 reserved wakes", {pwr_down, ready, 2'b00}, 4'b0000);
      chk("R6 mute after wake", {1'b0, out_mute, eq_bypass, eq_en}, 4'b0101);
      tick(WAKE - 1);
      chk("R10 ready held", {3'b000, ready}, 4'b0000);
      tick(1);
      chk("R10 ready after wake", {3'b000, ready}, 4'b0001);

      // R9 auto sleep with cancellation
      reg_mute = 0; reg_sleep = 2'b01; energy_det = 1;
      tick(1);
      energy_det = 0;
      tick(PDN);
      chk("R9 no sleep before timeout", {2'b00, pwr_down, ready}, 4'b0001);
      energy_det = 1;
      tick(1);
      chk("R9 cancel on return", {2'b00, pwr_down, ready}, 4'b0001);
      energy_det = 0;
      tick(PDN);
      chk("R9 still awake", {3'b000, pwr_down}, 4'b0000);
      tick(1);
      chk("R9 sleep at timeout", {1'b0, no_carrier, pwr_down, ready}, 4'b0110);
      // R10 automatic wake
      energy_det = 1;
      tick(1);
      chk("R10 wake power", {2'b00, pwr_down, ready}, 4'b0000);
      tick(WAKE - 1);
      chk("R10 ready held auto", {3'b000, ready}, 4'b0000);
      tick(1);
      chk("R10 ready auto", {3'b000, ready}, 4'b0001);

      // R11 mode 00 never sleeps
      reg_sleep = 2'b00; energy_det = 0;
      tick(PDN + 3);
      chk("R11 always on", {2'b00, pwr_down, ready}, 4'b0001);

      // R5 pin auto-sleep
      reg_ctl = 0; pin_autosleep = 1;
      tick(PDN);
      chk("R5 pin auto before timeout", {3'b000, pwr_down}, 4'b0000);
      tick(1);
      chk("R5 pin auto sleeps", {3'b000, pwr_down}, 4'b0001);
      pin_autosleep = 0;
      tick(1);
      chk("R5 pin auto off wakes", {3'b000, pwr_down}, 4'b0000);
      tick(WAKE);
      chk("R5 ready after pin wake", {3'b000, ready}, 4'b0001);

      // R12 acquisition restart
      reg_ctl = 1; reg_mute = 1; reg_sleep = 2'b00; energy_det = 1;
      tick(1);
      acq_rst = 1;
      tick(1);
      acq_rst = 0;
      chk("R12 restart clears", {1'b0, pwr_down, ready, out_mute}, 4'b0001);
      tick(WAKE - 1);
      chk("R12 ready held restart", {3'b000, ready}, 4'b0000);
      tick(1);
      chk("R12 ready after restart", {2'b00, ready, out_mute}, 4'b0011);
      reg_mute = 0; reg_sleep = 2'b01; energy_det = 0;
      tick(PDN + 1);
      chk("R9 sleep before restart", {3'b000, pwr_down}, 4'b0001);
      acq_rst = 1;
      tick(1);
      acq_rst = 0;
      chk("R12 restart wakes", {2'b00, pwr_down, ready}, 4'b0000);
      tick(1);
      chk("R9 resleep quiet input", {3'b000, pwr_down}, 4'b0001);

      report();
   end

endmodule